// File: doc/BRIEF.md
# Register Dependency Interlock Unit

This block sits at the issue stage of an in-order core and decides how long a decoded instruction must wait before it may issue. Every instruction arrives with a producer kind, which states how it writes its destination register, a destination register number, a consumer kind, which states what sort of operation it is, and up to `NSRC` source register numbers, each with its own valid bit. The block keeps a short history of recently issued producers. If the presented instruction reads a register that one of them wrote, it raises `hold` and reports the remaining wait on `stall_cnt`.

The size of the penalty depends on the pair of producer kind and consumer kind. It is not a fixed pipeline depth. Each instruction issued between the producer and the consumer reduces it by one, and so does each cycle with no instruction presented. While the consumer waits, the history keeps ageing, so the penalty counts down until the instruction can issue. The held instruction is not recorded while it waits; it is recorded only on the cycle it issues. A flush empties the history and drops the instruction presented in that cycle.

Top module: `dep_interlock`

## Requirements
- R1: While reset is active and after it is released, with an empty history, `hold` is 0 and `stall_cnt` is 0.
- R2: Producer kinds are coded on `in_wr_kind` as 0 no write, 1 data register from accumulator, 2 data register from system register, 3 data register from sequencer register, 4 data register loaded from a memory-mapped register, 5 pointer or address register written from a data register, 6 pointer or address register loaded or popped from memory. Consumer kinds are coded on `in_use_kind` as 0 other, 1 ALU, 2 multiply, 3 video/byte. A producer charges a penalty only when a source slot whose `in_src_vld` bit is 1 carries the same register number as that producer's destination.
- R3: Kind 1 followed by a video consumer costs 1 stall. Followed by any other consumer it costs none.
- R4: Kind 2 followed by a multiply or video consumer costs 1 stall. Followed by an ALU consumer it costs none.
- R5: Kind 5 followed by any consumer costs 4 stalls, and 4 is the largest value `stall_cnt` ever shows.
- R6: Kind 6 followed by any consumer costs 3 stalls.
- R7: Kinds 3 and 4 followed by an ALU consumer cost 1 stall. Followed by a multiply consumer they cost none.
- R8: With k instructions or idle cycles between producer and consumer, the stall is max(0, penalty − k).
- R9: While `hold` is 1 and the presented instruction stays the same, `stall_cnt` falls by one each cycle, and the instruction issues in the first cycle in which it reaches 0. A held instruction enters the history only when it issues, so a consumer right behind it still pays the full penalty owed to it.
- R10: When several history entries match, the stall is the largest remaining penalty among them.
- R11: In a cycle with `flush` high, `hold` and `stall_cnt` are 0, the presented instruction is dropped, and the history is cleared, so later consumers pay nothing for earlier producers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Pipeline flush: clear history, drop the presented instruction |
| in_valid | input | 1 | An instruction is presented for issue |
| in_wr_kind | input | 3 | Producer kind of the presented instruction |
| in_dst | input | REG_W | Destination register number |
| in_use_kind | input | 2 | Consumer kind of the presented instruction |
| in_src_vld | input | NSRC | Valid bit for each source slot |
| in_src_id | input | NSRC*REG_W | Source register numbers, slot 0 in the low bits |
| hold | output | 1 | The presented instruction must not issue this cycle |
| stall_cnt | output | 3 | Stall cycles still owed by the presented instruction |

## Verification
The hardest case to reach is a countdown that overlaps several live producers. In that case the remaining wait comes from whichever entry is largest. That entry may have aged during a previous stall, and the instruction being held must not count as a separator. The stimulus reaches this case by issuing two pointer producers with different penalties back to back, followed by a consumer that reads both. It also issues a stalled instruction that is itself a producer, followed immediately by a consumer of its result. A scoreboard stores the stall expected for each instruction. For every cycle in which the instruction is held, it compares `stall_cnt` against the expected remaining value, and it compares the total number of held cycles when the instruction issues.

// File: rtl/dil_pkg.sv
package dil_pkg;

  localparam int MAX_PEN = 4;
  localparam int PEN_W   = $clog2(MAX_PEN + 1);
  localparam int AGE_W   = $clog2(MAX_PEN + 2);
  localparam int KIND_W  = 3;
  localparam int USE_W   = 2;

  typedef enum logic [KIND_W-1:0] {
    WR_NONE    = 3'd0,
    WR_D_ACC   = 3'd1,
    WR_D_SYS   = 3'd2,
    WR_D_SEQ   = 3'd3,
    WR_D_MMR   = 3'd4,
    WR_PA_DREG = 3'd5,
    WR_PA_MEM  = 3'd6
  } wr_kind_e;

  typedef enum logic [USE_W-1:0] {
    USE_OTHER = 2'd0,
    USE_ALU   = 2'd1,
    USE_MUL   = 2'd2,
    USE_VIDEO = 2'd3
  } use_kind_e;

  // Penalty owed by a consumer of kind u reading a register set by producer kind w.
  function automatic logic [PEN_W-1:0] pair_penalty(wr_kind_e w, use_kind_e u);
    logic [PEN_W-1:0] p;
    p = '0;
    case (w)
      WR_D_ACC:   p = (u == USE_VIDEO) ? PEN_W'(1) : '0;
      WR_D_SYS:   p = (u == USE_MUL || u == USE_VIDEO) ? PEN_W'(1) : '0;
      WR_D_SEQ,
      WR_D_MMR:   p = (u == USE_ALU) ? PEN_W'(1) : '0;
      WR_PA_DREG: p = PEN_W'(4);
      WR_PA_MEM:  p = PEN_W'(3);
      default:    p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dil_rst_sync.sv
module dil_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/dil_history.sv
module dil_history
  import dil_pkg::*;
#(
  parameter int HIST  = 4,
  parameter int REG_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          push,
  input  logic [KIND_W-1:0]             push_kind,
  input  logic [REG_W-1:0]              push_dst,
  output logic [HIST-1:0]               ent_vld,
  output logic [HIST-1:0][KIND_W-1:0]   ent_kind,
  output logic [HIST-1:0][REG_W-1:0]    ent_dst,
  output logic [HIST-1:0][AGE_W-1:0]    ent_age
);

  localparam logic [AGE_W-1:0] AGE_SAT = '1;

  logic [HIST-1:0]             vld_q,  vld_d;
  logic [HIST-1:0][KIND_W-1:0] kind_q, kind_d;
  logic [HIST-1:0][REG_W-1:0]  dst_q,  dst_d;
  logic [HIST-1:0][AGE_W-1:0]  age_q,  age_d, aged;
  logic                        upd_en;

  // Every cycle counts as one step of separation; saturate so old entries stay harmless.
  always_comb begin
    for (int i = 0; i < HIST; i++) begin
      aged[i] = (age_q[i] == AGE_SAT) ? age_q[i] : age_q[i] + AGE_W'(1);
    end
  end

  always_comb begin
    vld_d  = vld_q;
    kind_d = kind_q;
    dst_d  = dst_q;
    age_d  = aged;
    if (clr) begin
      vld_d = '0;
    end else if (push) begin
      vld_d  = {vld_q[HIST-2:0], 1'b1};
      kind_d = {kind_q[HIST-2:0], push_kind};
      dst_d  = {dst_q[HIST-2:0], push_dst};
      age_d  = {aged[HIST-2:0], AGE_W'(0)};
    end
  end

  assign upd_en = clr | push | (|vld_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      kind_q <= '0;
      dst_q  <= '0;
      age_q  <= '0;
    end else if (upd_en) begin
      vld_q  <= vld_d;
      kind_q <= kind_d;
      dst_q  <= dst_d;
      age_q  <= age_d;
    end
  end

  assign ent_vld  = vld_q;
  assign ent_kind = kind_q;
  assign ent_dst  = dst_q;
  assign ent_age  = age_q;

  AST_PUSH_STARTS_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |=> (ent_vld[0] && ent_age[0] == '0)); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ent_vld == '0)); // R11

endmodule

// File: rtl/dil_scan.sv
module dil_scan
  import dil_pkg::*;
#(
  parameter int HIST  = 4,
  parameter int REG_W = 5,
  parameter int NSRC  = 3
) (
  input  logic [HIST-1:0]             ent_vld,
  input  logic [HIST-1:0][KIND_W-1:0] ent_kind,
  input  logic [HIST-1:0][REG_W-1:0]  ent_dst,
  input  logic [HIST-1:0][AGE_W-1:0]  ent_age,
  input  logic [USE_W-1:0]            use_kind,
  input  logic [NSRC-1:0]             src_vld,
  input  logic [NSRC*REG_W-1:0]       src_id,
  output logic [PEN_W-1:0]            need
);

  logic [HIST-1:0][PEN_W-1:0] rem;

  for (genvar i = 0; i < HIST; i++) begin : g_ent
    logic             hit;
    logic [PEN_W-1:0] pen;
    always_comb begin
      hit = 1'b0;
      for (int j = 0; j < NSRC; j++) begin
        if (src_vld[j] && src_id[j*REG_W +: REG_W] == ent_dst[i]) hit = 1'b1;
      end
      pen = pair_penalty(wr_kind_e'(ent_kind[i]), use_kind_e'(use_kind));
      if (ent_vld[i] && hit && (int'(pen) > int'(ent_age[i])))
        rem[i] = PEN_W'(int'(pen) - int'(ent_age[i]));
      else
        rem[i] = '0;
    end
  end

  always_comb begin
    need = '0;
    for (int i = 0; i < HIST; i++) begin
      if (rem[i] > need) need = rem[i];
    end
  end

endmodule

// File: rtl/dep_interlock.sv
module dep_interlock
  import dil_pkg::*;
#(
  parameter int HIST  = 4,
  parameter int REG_W = 5,
  parameter int NSRC  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  input  logic [2:0]              in_wr_kind,
  input  logic [REG_W-1:0]        in_dst,
  input  logic [1:0]              in_use_kind,
  input  logic [NSRC-1:0]         in_src_vld,
  input  logic [NSRC*REG_W-1:0]   in_src_id,
  output logic                    hold,
  output logic [2:0]              stall_cnt
);

  logic                        srst_n;
  logic                        push;
  logic [PEN_W-1:0]            need;
  logic [HIST-1:0]             h_vld;
  logic [HIST-1:0][KIND_W-1:0] h_kind;
  logic [HIST-1:0][REG_W-1:0]  h_dst;
  logic [HIST-1:0][AGE_W-1:0]  h_age;

  dil_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  dil_history #(.HIST(HIST), .REG_W(REG_W)) u_hist (
    .clk       (clk),
    .rst_n     (srst_n),
    .clr       (flush),
    .push      (push),
    .push_kind (in_wr_kind),
    .push_dst  (in_dst),
    .ent_vld   (h_vld),
    .ent_kind  (h_kind),
    .ent_dst   (h_dst),
    .ent_age   (h_age)
  );

  dil_scan #(.HIST(HIST), .REG_W(REG_W), .NSRC(NSRC)) u_scan (
    .ent_vld  (h_vld),
    .ent_kind (h_kind),
    .ent_dst  (h_dst),
    .ent_age  (h_age),
    .use_kind (in_use_kind),
    .src_vld  (in_src_vld),
    .src_id   (in_src_id),
    .need     (need)
  );

  // A flushed instruction neither waits nor enters the history.
  always_comb begin
    hold      = in_valid && !flush && (need != '0);
    stall_cnt = (in_valid && !flush) ? 3'(need) : 3'd0;
    push      = in_valid && !flush && !hold && (in_wr_kind != WR_NONE);
  end

  AST_HOLD_NEEDS_INSN: assert property (@(posedge clk) disable iff (!srst_n)
    hold |-> (in_valid && !flush)); // R11

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!srst_n)
    stall_cnt <= 3'(MAX_PEN)); // R5

  AST_COUNTDOWN: assert property (@(posedge clk) disable iff (!srst_n)
    hold |=> (!in_valid || flush || !$stable(in_src_id) || !$stable(in_src_vld) ||
              !$stable(in_use_kind) || stall_cnt == 3'($past(stall_cnt) - 3'd1))); // R9

  AST_FLUSH_FORGETS: assert property (@(posedge clk) disable iff (!srst_n)
    flush |=> (stall_cnt == 3'd0)); // R11

endmodule

// File: tb/dep_interlock_test.sv
`timescale 1ns/1ps
module dep_interlock_test;

  localparam int REG_W = 5;
  localparam int NSRC  = 3;

  logic                  clk = 1'b0;
  logic                  rst_n, flush, in_valid;
  logic [2:0]            in_wr_kind;
  logic [REG_W-1:0]      in_dst;
  logic [1:0]            in_use_kind;
  logic [NSRC-1:0]       in_src_vld;
  logic [NSRC*REG_W-1:0] in_src_id;
  logic                  hold;
  logic [2:0]            stall_cnt;

  always #2.5 clk = ~clk;

  dep_interlock uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_wr_kind(in_wr_kind), .in_dst(in_dst), .in_use_kind(in_use_kind),
    .in_src_vld(in_src_vld), .in_src_id(in_src_id),
    .hold(hold), .stall_cnt(stall_cnt)
  );

  typedef struct { int exp; string tag; } item_t;
  item_t sbq[$];
  int total = 0;
  int bad   = 0;
  int held  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(input int wk, input int dst, input int uk,
                       input int s0, input int s1, input int s2, input logic [2:0] sv);
    in_wr_kind  = 3'(wk);
    in_dst      = REG_W'(dst);
    in_use_kind = 2'(uk);
    in_src_vld  = sv;
    in_src_id   = {REG_W'(s2), REG_W'(s1), REG_W'(s0)};
  endtask

  // Driver: presents one instruction and waits until it is allowed to issue.
  task automatic send(input int wk, input int dst, input int uk, input int s0, input int s1,
                      input int s2, input logic [2:0] sv, input int exp, input string tag);
    @(posedge clk); #1;
    drive(wk, dst, uk, s0, s1, s2, sv);
    in_valid = 1'b1;
    sbq.push_back('{exp, tag});
    do @(negedge clk); while (hold);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (n - 1) @(posedge clk);
  endtask

  // Monitor: compares the per-cycle countdown and the total wait with the queue front.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && in_valid && !flush && sbq.size() != 0) begin
        if (hold) begin
          chk(int'(stall_cnt) == sbq[0].exp - held, sbq[0].tag, int'(stall_cnt), sbq[0].exp - held);
          held++;
        end else begin
          chk(held == sbq[0].exp, sbq[0].tag, held, sbq[0].exp);
          chk(stall_cnt == 3'd0, sbq[0].tag, int'(stall_cnt), 0);
          void'(sbq.pop_front());
          held = 0;
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 3'b000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(hold == 1'b0, "R1", int'(hold), 0);
    chk(stall_cnt == 3'd0, "R1", int'(stall_cnt), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    send(0, 0, 1, 3, 0, 0, 3'b001, 0, "R1");
    idle(6);

    // R3: accumulator-fed data register
    send(1, 1, 0, 0, 0, 0, 3'b000, 0, "R3");
    send(0, 0, 3, 1, 0, 0, 3'b001, 1, "R3");
    idle(6);
    send(1, 2, 0, 0, 0, 0, 3'b000, 0, "R3");
    send(0, 0, 1, 2, 0, 0, 3'b001, 0, "R3");
    idle(6);

    // R4: system-register-fed data register
    send(2, 3, 0, 0, 0, 0, 3'b000, 0, "R4");
    send(0, 0, 2, 3, 0, 0, 3'b001, 1, "R4");
    idle(6);
    send(2, 4, 0, 0, 0, 0, 3'b000, 0, "R4");
    send(0, 0, 3, 0, 4, 0, 3'b010, 1, "R4");
    idle(6);
    send(2, 5, 0, 0, 0, 0, 3'b000, 0, "R4");
    send(0, 0, 1, 5, 0, 0, 3'b001, 0, "R4");
    idle(6);

    // R5: pointer written from a data register
    send(5, 8, 0, 0, 0, 0, 3'b000, 0, "R5");
    send(0, 0, 0, 8, 0, 0, 3'b001, 4, "R5");
    idle(6);
    send(5, 9, 0, 0, 0, 0, 3'b000, 0, "R5");
    send(0, 0, 1, 0, 0, 9, 3'b100, 4, "R5");
    idle(6);

    // R6: pointer loaded from memory
    send(6, 11, 0, 0, 0, 0, 3'b000, 0, "R6");
    send(0, 0, 1, 11, 0, 0, 3'b001, 3, "R6");
    idle(6);
    send(6, 16, 0, 0, 0, 0, 3'b000, 0, "R6");
    send(0, 0, 3, 16, 0, 0, 3'b001, 3, "R6");
    idle(6);

    // R7: sequencer and memory-mapped sources
    send(3, 0, 0, 0, 0, 0, 3'b000, 0, "R7");
    send(0, 0, 1, 0, 0, 0, 3'b001, 1, "R7");
    idle(6);
    send(4, 6, 0, 0, 0, 0, 3'b000, 0, "R7");
    send(0, 0, 1, 6, 0, 0, 3'b001, 1, "R7");
    idle(6);
    send(3, 7, 0, 0, 0, 0, 3'b000, 0, "R7");
    send(0, 0, 2, 7, 0, 0, 3'b001, 0, "R7");
    idle(6);

    // R2: register mismatch and an invalid slot carrying the matching number
    send(5, 8, 0, 0, 0, 0, 3'b000, 0, "R2");
    send(0, 0, 1, 9, 0, 0, 3'b001, 0, "R2");
    idle(6);
    send(5, 8, 0, 0, 0, 0, 3'b000, 0, "R2");
    send(0, 0, 1, 8, 0, 0, 3'b010, 0, "R2");
    idle(6);

    // R8: separation by instructions and by idle cycles
    send(5, 12, 0, 0, 0, 0, 3'b000, 0, "R8");
    send(0, 0, 0, 0, 0, 0, 3'b000, 0, "R8");
    send(0, 0, 1, 12, 0, 0, 3'b001, 3, "R8");
    idle(6);
    send(5, 12, 0, 0, 0, 0, 3'b000, 0, "R8");
    for (int i = 0; i < 2; i++) send(0, 0, 0, 0, 0, 0, 3'b000, 0, "R8");
    send(0, 0, 1, 12, 0, 0, 3'b001, 2, "R8");
    idle(6);
    send(5, 12, 0, 0, 0, 0, 3'b000, 0, "R8");
    for (int i = 0; i < 4; i++) send(0, 0, 0, 0, 0, 0, 3'b000, 0, "R8");
    send(0, 0, 1, 12, 0, 0, 3'b001, 0, "R8");
    idle(6);
    send(5, 12, 0, 0, 0, 0, 3'b000, 0, "R8");
    idle(2);
    send(0, 0, 1, 12, 0, 0, 3'b001, 2, "R8");
    idle(6);

    // R10: largest remaining penalty wins
    send(6, 9, 0, 0, 0, 0, 3'b000, 0, "R10");
    send(5, 10, 0, 0, 0, 0, 3'b000, 0, "R10");
    send(0, 0, 1, 9, 10, 0, 3'b011, 4, "R10");
    idle(6);
    send(5, 10, 0, 0, 0, 0, 3'b000, 0, "R10");
    send(6, 9, 0, 0, 0, 0, 3'b000, 0, "R10");
    send(0, 0, 1, 10, 9, 0, 3'b011, 3, "R10");
    idle(6);

    // R9: a held producer enters history only when it issues
    send(5, 8, 0, 0, 0, 0, 3'b000, 0, "R9");
    send(5, 13, 1, 8, 0, 0, 3'b001, 4, "R9");
    send(0, 0, 1, 13, 0, 0, 3'b001, 4, "R9");
    idle(6);

    // R11: flush clears history and drops the presented instruction
    send(5, 14, 0, 0, 0, 0, 3'b000, 0, "R11");
    @(posedge clk); #1;
    drive(5, 15, 1, 14, 0, 0, 3'b001);
    in_valid = 1'b1;
    flush    = 1'b1;
    @(negedge clk);
    chk(hold == 1'b0, "R11", int'(hold), 0);
    chk(stall_cnt == 3'd0, "R11", int'(stall_cnt), 0);
    @(posedge clk); #1;
    flush    = 1'b0;
    in_valid = 1'b0;
    send(0, 0, 1, 14, 15, 0, 3'b011, 0, "R11");
    idle(6);

    chk(sbq.size() == 0, "R9", sbq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule